// File: doc/BRIEF.md
# Multiplexed Dot Matrix Scanner

This block turns a small store of character codes into the row and column drive patterns for a bank of eight 5x7 dot-matrix digits. The digits form two groups of four. Every scan step lights one row of one group and presents twenty column bits, five for each digit in that group. Fourteen steps, seven rows in each group, refresh the whole bank once. A code with its top bit clear is turned into a row pattern by a built-in glyph lookup. A code with its top bit set selects a pattern slot in a user-defined pattern store instead.

Each scan step is split into PWM slots. The first slot of every step is always dark, so that no column is lit while the rows change over. In the remaining slots the columns are on for a number of slots set by a 3-bit brightness level in the control word. The peak drive never changes; only the on-time does. A per-digit flash bit, when flashing is enabled globally, ANDs that digit's columns with a slow square wave. The square wave comes from a frame counter.

The contents are loaded through a single-cycle write strobe. One target field picks character, flash, control or pattern storage. The scanner free-runs from reset.

Top module: `dotmatrix_scanner`

## Requirements
- R1: Reset (synchronous, active low) sets every character code to 8'h20, every flash bit to 0, and the control word to 0 (full brightness, flashing off). It restarts the scan at step 0 with the PWM slot at 0. As a result, `rows_o` is 14'h0001 and `cols_o` stays all zero over the whole first frame.
- R2: A scan step lasts PWM_STEPS (16) clocks. Steps run 0..13 and then wrap. During step s, `rows_o` is one-hot with only bit s set. Steps 0-6 are rows 0-6 of group 0 (digits 0-3). Steps 7-13 are rows 0-6 of group 1 (digits 4-7).
- R3: In step s, lane k (0..3) shows digit 4*(s/7)+k at row s%7. Column c (0..4) of that lane drives `cols_o[5*k+c]` from bit c of the digit's row pattern.
- R4: For a code with bit 7 clear, the row pattern comes from bits [6:0]. Values 0..32 give 5'b00000. Value 127 gives 5'b11111. Any other value gives its low five bits XORed with the row number.
- R5: In PWM slot 0 of every step (the first clock after a row change), `cols_o` is all zero.
- R6: Control bits [2:0] give a level L. In slots 1..N the columns follow the pattern, and in all other slots they are zero. N is 15, 12, 8, 6, 4, 3, 2 or 0 for L = 0..7, which gives about 100, 80, 53, 40, 27, 20, 13 and 0 percent.
- R7: When control bit 3 is set and a digit's flash bit is 1, that digit's columns are zero while the flash phase is off. The phase is on after reset and toggles each time FLASH_FRAMES whole frames have completed.
- R8: When control bit 3 is clear, the flash bits have no effect on `cols_o` in either flash phase.
- R9: For a code with bit 7 set, the row pattern is bits [4:0] of pattern slot code[3:0] at the current row.
- R10: A write with `wr_en` high takes effect on that clock edge, so it is visible on the outputs in the next cycle. The `wr_tgt` values are:
  - 0: character code of digit `wr_addr[2:0]`, taken from `wr_data`.
  - 1: flash bit of digit `wr_addr[2:0]`, taken from `wr_data[0]`.
  - 2: control word, taken from `wr_data[3:0]`.
  - 3: row pattern at slot `wr_addr[6:3]`, row `wr_addr[2:0]`, taken from `wr_data[4:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_tgt | input | 2 | Write target: 0 char, 1 flash, 2 control, 3 pattern |
| wr_addr | input | 7 | Digit index, or pattern slot and row |
| wr_data | input | 8 | Write data |
| rows_o | output | 14 | One-hot row drive across both groups |
| cols_o | output | 20 | Column drive for the four lanes of the active group |

## Verification
The case that is hardest to reach from the ports is a flashing digit during the off phase of the flash square wave. That phase begins only after FLASH_FRAMES whole refresh frames. The bench therefore builds the scanner with FLASH_FRAMES set to 2. It sets flash bits on a mix of digits and runs several frames with global flashing disabled and then enabled, so that both phases occur under both settings. Each brightness level, and pattern-slot codes alongside glyph codes, are held for a full frame. This lets every row of both groups be compared against the behavioural model.

// File: rtl/dm_scan_pkg.sv
// Shared constants, write-target encoding and lookup functions for the
// dot-matrix scanner. Assumes a 5x7 glyph cell and 8-bit character codes.
package dm_scan_pkg;

    localparam int GLYPH_W = 5;
    localparam int GLYPH_H = 7;
    localparam int CODE_W  = 8;
    localparam int CTRL_W  = 4;

    typedef enum logic [1:0] {
        TGT_CHAR  = 2'd0,
        TGT_FLASH = 2'd1,
        TGT_CTRL  = 2'd2,
        TGT_UDC   = 2'd3
    } wr_tgt_e;

    // Behavioural glyph ROM: one row of a computed 5-wide glyph.
    function automatic logic [GLYPH_W-1:0] rom_row(input logic [6:0] code,
                                                   input logic [2:0] row);
        logic [GLYPH_W-1:0] r;
        if (code <= 7'h20) begin
            r = '0;
        end else if (code == 7'h7F) begin
            r = '1;
        end else begin
            r = code[4:0] ^ {2'b00, row};
        end
        return r;
    endfunction

    // Number of lit PWM slots for a brightness level, scaled from fifteenths.
    function automatic int unsigned duty_slots(input logic [2:0] lvl,
                                               input int unsigned active);
        int unsigned k;
        case (lvl)
            3'd0:    k = 15;
            3'd1:    k = 12;
            3'd2:    k = 8;
            3'd3:    k = 6;
            3'd4:    k = 4;
            3'd5:    k = 3;
            3'd6:    k = 2;
            default: k = 0;
        endcase
        return (active * k) / 15;
    endfunction

endpackage

// File: rtl/dm_scan_timer.sv
// Scan timing: PWM slot counter inside each step, step counter across the
// frame, and the flash square wave derived from whole frames.
// Assumes PWM_STEPS >= 2, N_STEPS >= 2, FLASH_FRAMES >= 1.
module dm_scan_timer #(
    parameter int PWM_STEPS    = 16,
    parameter int N_STEPS      = 14,
    parameter int FLASH_FRAMES = 60,
    parameter int PW           = $clog2(PWM_STEPS),
    parameter int SW           = $clog2(N_STEPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] pwm_cnt,
    output logic [SW-1:0] step_idx,
    output logic          flash_phase
);

    localparam int FW = $clog2(FLASH_FRAMES) + 1;

    logic          pwm_last;
    logic          step_last;
    logic          flash_due;
    logic [FW-1:0] frame_cnt;

    // Decode end of slot run, end of frame and flash interval.
    always_comb begin
        pwm_last  = (pwm_cnt == PW'(PWM_STEPS - 1));
        step_last = (step_idx == SW'(N_STEPS - 1));
        flash_due = (frame_cnt == FW'(FLASH_FRAMES - 1));
    end

    // PWM slot counter, wraps every step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_cnt <= '0;
        end else if (pwm_last) begin
            pwm_cnt <= '0;
        end else begin
            pwm_cnt <= pwm_cnt + 1'b1;
        end
    end

    // Scan step counter, advances at the end of each slot run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_idx <= '0;
        end else if (pwm_last) begin
            step_idx <= step_last ? '0 : step_idx + 1'b1;
        end
    end

    // Frame counter and flash phase toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_cnt   <= '0;
            flash_phase <= 1'b1;
        end else if (pwm_last && step_last) begin
            if (flash_due) begin
                frame_cnt   <= '0;
                flash_phase <= ~flash_phase;
            end else begin
                frame_cnt <= frame_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dm_disp_store.sv
// Display contents: character codes, flash bits, control word and the
// user-defined row pattern store, all written through one strobe.
// Assumes N_DIGITS is a power of two and rows fit in a 3-bit field.
module dm_disp_store
    import dm_scan_pkg::*;
#(
    parameter int N_DIGITS = 8,
    parameter int N_UDC    = 16,
    parameter int UW       = $clog2(N_UDC),
    parameter int AW       = UW + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_tgt,
    input  logic [AW-1:0]      wr_addr,
    input  logic [CODE_W-1:0]  wr_data,
    output logic [CODE_W-1:0]  char_q  [N_DIGITS],
    output logic [N_DIGITS-1:0] flash_q,
    output logic [CTRL_W-1:0]  ctrl_q,
    output logic [GLYPH_W-1:0] udc_q   [N_UDC][GLYPH_H]
);

    localparam int DW = $clog2(N_DIGITS);

    logic we_char, we_flash, we_ctrl, we_udc;

    // Decode the write target.
    always_comb begin
        we_char  = wr_en && (wr_tgt == TGT_CHAR);
        we_flash = wr_en && (wr_tgt == TGT_FLASH);
        we_ctrl  = wr_en && (wr_tgt == TGT_CTRL);
        we_udc   = wr_en && (wr_tgt == TGT_UDC);
    end

    for (genvar d = 0; d < N_DIGITS; d++) begin : g_digit
        // Character code and flash bit of one digit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                char_q[d]  <= 8'h20;
                flash_q[d] <= 1'b0;
            end else begin
                if (we_char && wr_addr[DW-1:0] == DW'(d)) char_q[d] <= wr_data;
                if (we_flash && wr_addr[DW-1:0] == DW'(d)) flash_q[d] <= wr_data[0];
            end
        end
    end

    // Control word: brightness level and global flash enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (we_ctrl) begin
            ctrl_q <= wr_data[CTRL_W-1:0];
        end
    end

    for (genvar s = 0; s < N_UDC; s++) begin : g_slot
        for (genvar r = 0; r < GLYPH_H; r++) begin : g_row
            // One row of one user-defined pattern.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    udc_q[s][r] <= '0;
                end else if (we_udc && wr_addr[AW-1:3] == UW'(s)
                             && wr_addr[2:0] == 3'(r)) begin
                    udc_q[s][r] <= wr_data[GLYPH_W-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/dm_row_fetch.sv
// Per-lane row pattern fetch: picks the digit of the active group for each
// lane and looks up its row in the glyph ROM or the pattern store.
module dm_row_fetch
    import dm_scan_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int N_DIGITS = 8,
    parameter int N_UDC    = 16,
    parameter int GW       = 1,
    parameter int UW       = $clog2(N_UDC)
) (
    input  logic [GW-1:0]       group_idx,
    input  logic [2:0]          row_idx,
    input  logic [CODE_W-1:0]   char_q   [N_DIGITS],
    input  logic [N_DIGITS-1:0] flash_q,
    input  logic [GLYPH_W-1:0]  udc_q    [N_UDC][GLYPH_H],
    output logic [GLYPH_W-1:0]  lane_pat [LANES],
    output logic [LANES-1:0]    lane_flash
);

    localparam int DW = $clog2(N_DIGITS);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [DW-1:0]     dig;
        logic [CODE_W-1:0] code;

        // Select the digit for this lane and fetch its row pattern.
        always_comb begin
            dig  = DW'(int'(group_idx) * LANES + l);
            code = char_q[dig];
            if (code[CODE_W-1]) begin
                lane_pat[l] = udc_q[code[UW-1:0]][row_idx];
            end else begin
                lane_pat[l] = rom_row(code[6:0], row_idx);
            end
            lane_flash[l] = flash_q[dig];
        end
    end

endmodule

// File: rtl/dm_col_gate.sv
// Column gating: blanks the first PWM slot, applies the brightness duty
// window and the per-digit flash gate to every lane.
module dm_col_gate
    import dm_scan_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int PWM_STEPS = 16,
    parameter int PW        = $clog2(PWM_STEPS)
) (
    input  logic [GLYPH_W-1:0]       lane_pat [LANES],
    input  logic [LANES-1:0]         lane_flash,
    input  logic [PW-1:0]            pwm_cnt,
    input  logic [CTRL_W-1:0]        ctrl_q,
    input  logic                     flash_phase,
    output logic [LANES*GLYPH_W-1:0] cols
);

    logic slot_on;

    // Duty window: slot 0 dark, then lit up to the level's slot count.
    always_comb begin
        slot_on = (pwm_cnt != '0) &&
                  (32'(pwm_cnt) <= duty_slots(ctrl_q[2:0], PWM_STEPS - 1));
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic flash_off;

        // Flash gate and duty window for one lane.
        always_comb begin
            flash_off = ctrl_q[3] && lane_flash[l] && !flash_phase;
            cols[l*GLYPH_W +: GLYPH_W] = (slot_on && !flash_off) ? lane_pat[l] : '0;
        end
    end

endmodule

// File: rtl/dotmatrix_scanner.sv
// Top of the dot-matrix scanner: stores display contents, steps through
// two groups of seven rows and drives twenty gated columns per step.
// Assumes N_DIGITS divisible by N_GROUPS and N_GROUPS >= 2.
module dotmatrix_scanner
    import dm_scan_pkg::*;
#(
    parameter int N_DIGITS     = 8,
    parameter int N_GROUPS     = 2,
    parameter int N_UDC        = 16,
    parameter int PWM_STEPS    = 16,
    parameter int FLASH_FRAMES = 60,
    localparam int LANES       = N_DIGITS / N_GROUPS,
    localparam int N_STEPS     = N_GROUPS * GLYPH_H,
    localparam int COLS        = LANES * GLYPH_W,
    localparam int UW          = $clog2(N_UDC),
    localparam int AW          = UW + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_tgt,
    input  logic [AW-1:0]      wr_addr,
    input  logic [CODE_W-1:0]  wr_data,
    output logic [N_STEPS-1:0] rows_o,
    output logic [COLS-1:0]    cols_o
);

    localparam int PW = $clog2(PWM_STEPS);
    localparam int SW = $clog2(N_STEPS);
    localparam int GW = $clog2(N_GROUPS);

    logic [PW-1:0]       pwm_cnt;
    logic [SW-1:0]       step_idx;
    logic                flash_phase;
    logic [GW-1:0]       group_idx;
    logic [2:0]          row_idx;
    logic [CODE_W-1:0]   char_q   [N_DIGITS];
    logic [N_DIGITS-1:0] flash_q;
    logic [CTRL_W-1:0]   ctrl_q;
    logic [GLYPH_W-1:0]  udc_q    [N_UDC][GLYPH_H];
    logic [GLYPH_W-1:0]  lane_pat [LANES];
    logic [LANES-1:0]    lane_flash;

    dm_scan_timer #(
        .PWM_STEPS   (PWM_STEPS),
        .N_STEPS     (N_STEPS),
        .FLASH_FRAMES(FLASH_FRAMES),
        .PW          (PW),
        .SW          (SW)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwm_cnt    (pwm_cnt),
        .step_idx   (step_idx),
        .flash_phase(flash_phase)
    );

    dm_disp_store #(
        .N_DIGITS(N_DIGITS),
        .N_UDC   (N_UDC),
        .UW      (UW),
        .AW      (AW)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_tgt (wr_tgt),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .char_q (char_q),
        .flash_q(flash_q),
        .ctrl_q (ctrl_q),
        .udc_q  (udc_q)
    );

    // Split the step number into group and row, and drive the one-hot rows.
    always_comb begin
        group_idx = GW'(step_idx / SW'(GLYPH_H));
        row_idx   = 3'(step_idx % SW'(GLYPH_H));
        rows_o    = N_STEPS'(1) << step_idx;
    end

    dm_row_fetch #(
        .LANES   (LANES),
        .N_DIGITS(N_DIGITS),
        .N_UDC   (N_UDC),
        .GW      (GW),
        .UW      (UW)
    ) u_fetch (
        .group_idx (group_idx),
        .row_idx   (row_idx),
        .char_q    (char_q),
        .flash_q   (flash_q),
        .udc_q     (udc_q),
        .lane_pat  (lane_pat),
        .lane_flash(lane_flash)
    );

    dm_col_gate #(
        .LANES    (LANES),
        .PWM_STEPS(PWM_STEPS),
        .PW       (PW)
    ) u_gate (
        .lane_pat   (lane_pat),
        .lane_flash (lane_flash),
        .pwm_cnt    (pwm_cnt),
        .ctrl_q     (ctrl_q),
        .flash_phase(flash_phase),
        .cols       (cols_o)
    );

endmodule

// File: rtl/dotmatrix_scanner_chk.sv
// Protocol checker for the dot-matrix scanner, attached by bind.
// Observes the row/column outputs and the timer and control state.
module dotmatrix_scanner_chk #(
    parameter int N_STEPS = 14,
    parameter int COLS    = 20,
    parameter int PW      = 4,
    parameter int SW      = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_STEPS-1:0] rows_o,
    input logic [COLS-1:0]    cols_o,
    input logic [PW-1:0]      pwm_cnt,
    input logic [SW-1:0]      step_idx,
    input logic [3:0]         ctrl_q,
    input logic               flash_phase
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (rows_o == N_STEPS'(1)) && (cols_o == '0));

    // R2
    rows_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rows_o) == 1);

    // R2
    row_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rows_o != $past(rows_o)) |->
            (rows_o == {$past(rows_o[N_STEPS-2:0]), $past(rows_o[N_STEPS-1])}));

    // R5
    blank_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_cnt == '0) |-> (cols_o == '0));

    // R6
    dark_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[2:0] == 3'd7) |-> (cols_o == '0));

    // R7
    flash_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((pwm_cnt == '0) && (step_idx == '0)) |-> $stable(flash_phase));

endmodule

bind dotmatrix_scanner dotmatrix_scanner_chk #(
    .N_STEPS(N_STEPS),
    .COLS   (COLS),
    .PW     (PW),
    .SW     (SW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rows_o     (rows_o),
    .cols_o     (cols_o),
    .pwm_cnt    (pwm_cnt),
    .step_idx   (step_idx),
    .ctrl_q     (ctrl_q),
    .flash_phase(flash_phase)
);

// File: tb/tb_dotmatrix_scanner.sv
// Bench: behavioural cycle model of the scanner compared on every clock.
module tb_dotmatrix_scanner;

    localparam int CLK_PERIOD = 10;
    localparam int FF         = 2;
    localparam int FRAME      = 14 * 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_tgt = '0;
    logic [6:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [13:0] rows_o;
    logic [19:0] cols_o;

    int checks = 0;
    int failures = 0;
    string cur_tag = "R1";

    // model state
    int m_char [8];
    int m_flash [8];
    int m_ctrl;
    int m_udc [16][7];
    int pc, st, fc, ph;

    dotmatrix_scanner #(.FLASH_FRAMES(FF)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_tgt (wr_tgt),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rows_o (rows_o),
        .cols_o (cols_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h (step %0d slot %0d)", tag, act, exp, st, pc);
        end
    endtask

    task automatic model_update();
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin m_char[i] = 32; m_flash[i] = 0; end
            for (int s = 0; s < 16; s++) for (int r = 0; r < 7; r++) m_udc[s][r] = 0;
            m_ctrl = 0; pc = 0; st = 0; fc = 0; ph = 1;
        end else begin
            if (wr_en) begin
                case (wr_tgt)
                    2'd0: m_char[wr_addr % 8] = wr_data;
                    2'd1: m_flash[wr_addr % 8] = wr_data[0];
                    2'd2: m_ctrl = wr_data % 16;
                    default: if (wr_addr % 8 < 7) m_udc[wr_addr / 8][wr_addr % 8] = wr_data % 32;
                endcase
            end
            pc++;
            if (pc == 16) begin
                pc = 0; st++;
                if (st == 14) begin
                    st = 0; fc++;
                    if (fc == FF) begin fc = 0; ph = 1 - ph; end
                end
            end
        end
    endtask

    function automatic logic [19:0] model_cols();
        logic [19:0] v = '0;
        int half = st / 7;
        int row = st % 7;
        int slots;
        case (m_ctrl % 8)
            0: slots = 15; 1: slots = 12; 2: slots = 8; 3: slots = 6;
            4: slots = 4;  5: slots = 3;  6: slots = 2; default: slots = 0;
        endcase
        for (int k = 0; k < 4; k++) begin
            int d = half * 4 + k;
            int code = m_char[d];
            int pat;
            bit gated;
            if (code >= 128) pat = m_udc[code % 16][row];
            else if (code <= 32) pat = 0;
            else if (code == 127) pat = 31;
            else pat = (code % 32) ^ row;
            gated = (m_ctrl / 8 == 1) && (m_flash[d] == 1) && (ph == 0);
            if (pc >= 1 && pc <= slots && !gated) v[k*5 +: 5] = 5'(pat);
        end
        return v;
    endfunction

    task automatic step_clk();
        @(posedge clk);
        #1;
        model_update();
        if (rst_n) begin
            chk("R2 rows", 32'(rows_o), 32'(14'(1) << st));
            chk(cur_tag, 32'(cols_o), 32'(model_cols()));
            if (pc == 0) chk("R5 blank slot", 32'(cols_o), 32'd0);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step_clk();
    endtask

    task automatic wr(input logic [1:0] t, input logic [6:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_tgt = t; wr_addr = a; wr_data = d;
        step_clk();
        wr_en = 1'b0;
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R2 watchdog act=timeout exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int lit;
        logic [7:0] udc_rows [7];
        udc_rows = '{8'h11, 8'h0A, 8'h04, 8'h1F, 8'h04, 8'h0A, 8'h11};
        run(3);
        rst_n = 1'b1;
        cur_tag = "R1 reset blank";
        step_clk();
        chk("R1 rows after reset", 32'(rows_o), 32'h1);
        chk("R1 cols after reset", 32'(cols_o), 32'h0);
        run(FRAME);

        cur_tag = "R10 writes";
        wr(2'd0, 7'd0, 8'h41);
        wr(2'd0, 7'd1, 8'h7F);
        wr(2'd0, 7'd3, 8'h83);
        wr(2'd0, 7'd4, 8'h5A);
        wr(2'd0, 7'd5, 8'h10);
        wr(2'd0, 7'd6, 8'h8C);
        wr(2'd0, 7'd7, 8'h66);
        for (int r = 0; r < 7; r++) wr(2'd3, 7'(3 * 8 + r), udc_rows[r]);
        for (int r = 0; r < 7; r++) wr(2'd3, 7'(12 * 8 + r), 8'(r + 9));

        cur_tag = "R4 glyph rows";
        run(FRAME);
        cur_tag = "R9 pattern slots";
        run(FRAME);
        cur_tag = "R3 lane mapping";
        run(FRAME);

        for (int lv = 0; lv < 8; lv++) begin
            cur_tag = "R6 brightness";
            wr(2'd2, 7'd0, 8'(lv));
            lit = 0;
            for (int i = 0; i < FRAME; i++) begin
                step_clk();
                if (cols_o != '0) lit++;
            end
            if (lv == 7) chk("R6 level 7 dark cycles", 32'(lit), 32'd0);
        end

        cur_tag = "R10 flash writes";
        wr(2'd2, 7'd0, 8'h00);
        wr(2'd1, 7'd0, 8'h01);
        wr(2'd1, 7'd2, 8'h01);
        wr(2'd1, 7'd5, 8'h01);
        wr(2'd1, 7'd7, 8'hFF);
        wr(2'd1, 7'd1, 8'h01);
        cur_tag = "R8 flash ignored";
        run(FRAME * 5);

        cur_tag = "R7 flash gate";
        wr(2'd2, 7'd0, 8'h08);
        run(FRAME * 6);
        wr(2'd2, 7'd0, 8'h09);
        run(FRAME * 3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule